// File: doc/BRIEF.md
# Serial Management Frame Slave

This block is the target side of a two-wire serial management link. It takes one bit from the shared data line on every rising edge of the management clock. It recognises the start marker and collects the operation code, the device address and the register address. It then either returns the contents of a register or accepts a new value for it. On the register side it talks to a simple register file through five signals: an address, write data, a write strobe, a read strobe, and read data that must be valid in the same cycle it is requested. On the line side it provides a data output and an output enable for an external tri-state buffer.

The device-address field is accepted but never compared, so the block answers every address on the bus. The host tells the block which way the line is going with `host_listen`, which is high in every cycle in which the host samples the line instead of driving it. If the host samples when the block is not talking, or drives when the block is talking, the frame is dropped and the block goes back to idle.

Top module: `mgmt_frame_slave`

## Requirements
- R1: In idle, a driven 1 keeps the block idle; a driven 0 moves it to the start state.
- R2: In the start state, further driven 0s keep it waiting there; a driven 1 opens the address phase.
- R3: The address phase takes 12 driven bits, MSB first: opcode (2 bits), device address (5 bits, any value accepted), register address (5 bits).
- R4: Opcode binary 10 is a read. On the last address bit, `reg_re` pulses for one cycle with `reg_addr` equal to the register address, and `reg_rdata` is captured in that cycle.
- R5: A read has exactly one turnaround cycle, with `mdio_oe`=1 and `mdio_o`=0.
- R6: After the turnaround, the 16 captured bits appear on `mdio_o` MSB first, one per cycle, with `mdio_oe`=1. After that the block is idle and `mdio_oe`=0.
- R7: Opcode binary 01 is a write. Two turnaround bits are discarded, then 16 data bits are taken MSB first. On the 16th bit, `reg_we` pulses once with the saved register address and the assembled data.
- R8: Opcodes 00 and 11 send the block back to idle with no strobe and no drive.
- R9: If the host samples (`host_listen`=1) in any state other than read turnaround or read data, or drives during those two states, the block drops to idle with `mdio_o`=0 and no strobe.
- R10: `mdio_oe` is high only in the read turnaround and read data cycles.
- R11: A synchronous reset forces idle with no drive and no strobe, and clears the counter and shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; the line is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mdio_i | input | 1 | Sampled data line |
| host_listen | input | 1 | High in cycles in which the host samples instead of driving |
| mdio_o | output | 1 | Data driven toward the line |
| mdio_oe | output | 1 | Output enable for the line buffer |
| reg_addr | output | AW | Register-file address |
| reg_wdata | output | DW | Register-file write data |
| reg_we | output | 1 | Register-file write strobe |
| reg_re | output | 1 | Register-file read strobe |
| reg_rdata | input | DW | Register-file read data, same cycle |

## Verification
A wrong state or bit count shows up at the ports in one of a few ways. The enable may rise a cycle early or late, a strobe may land on the wrong address bit, or a read may return a value shifted by one place. Each of these appears within the frame that caused it, so the bench compares every cycle of every frame. A block that fails to drop out after an abort or a bad opcode keeps driving, or strobes, during the next frame, so each error case is followed at once by a clean transaction.

// File: rtl/mgmt_frame_slave.sv
module mgmt_frame_slave #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdio_i,
  input  logic          host_listen,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int HDR = 2 + 2*AW;
  localparam int CW  = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ST, S_ADR, S_TARD, S_TAWR, S_RD, S_WR} st_t;

  st_t            state;
  logic [DW-1:0]  sh;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  addr_q;

  wire           last = (cnt == CW'(1));
  wire [DW-1:0]  nxt  = {sh[DW-2:0], mdio_i};
  wire [1:0]     op   = nxt[HDR-1:HDR-2];
  wire           hdr_done = (state == S_ADR) && last && !host_listen;

  assign reg_re    = hdr_done && (op == 2'b10);
  assign reg_addr  = (state == S_ADR) ? nxt[AW-1:0] : addr_q;
  assign reg_we    = (state == S_WR) && last && !host_listen;
  assign reg_wdata = nxt;
  assign mdio_oe   = (state == S_TARD) || (state == S_RD);
  assign mdio_o    = (state == S_RD) && sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (!host_listen && !mdio_i) state <= S_ST;
        S_ST: begin
          if (host_listen) state <= S_IDLE;
          else if (mdio_i) begin
            state <= S_ADR;
            cnt   <= CW'(HDR);
            sh    <= '0;
          end
        end
        S_ADR: begin
          if (host_listen) state <= S_IDLE;
          else begin
            sh  <= nxt;
            cnt <= cnt - CW'(1);
            if (last) begin
              case (op)
                2'b10: begin
                  sh    <= reg_rdata;
                  state <= S_TARD;
                end
                2'b01: begin
                  addr_q <= nxt[AW-1:0];
                  cnt    <= CW'(2);
                  state  <= S_TAWR;
                end
                default: state <= S_IDLE;
              endcase
            end
          end
        end
        S_TARD: begin
          if (!host_listen) state <= S_IDLE;
          else begin
            state <= S_RD;
            cnt   <= CW'(DW);
          end
        end
        S_RD: begin
          if (!host_listen) state <= S_IDLE;
          else begin
            sh  <= sh << 1;
            cnt <= cnt - CW'(1);
            if (last) state <= S_IDLE;
          end
        end
        S_TAWR: begin
          if (host_listen) state <= S_IDLE;
          else begin
            cnt <= cnt - CW'(1);
            if (last) begin
              state <= S_WR;
              cnt   <= CW'(DW);
            end
          end
        end
        S_WR: begin
          if (host_listen) state <= S_IDLE;
          else begin
            sh  <= nxt;
            cnt <= cnt - CW'(1);
            if (last) state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst) !(reg_re && reg_we));
  p_re_then_ta_r5: assert property (@(posedge clk) disable iff (rst) reg_re |=> (mdio_oe && !mdio_o));
  p_we_single_r7: assert property (@(posedge clk) disable iff (rst) reg_we |=> (!reg_we && !mdio_oe));
  p_drive_abort_r9: assert property (@(posedge clk) disable iff (rst) (mdio_oe && !host_listen) |=> !mdio_oe);
  p_oe_rise_r10: assert property (@(posedge clk) disable iff (rst) $rose(mdio_oe) |-> (!mdio_o && $past(reg_re)));
  p_reset_quiet_r11: assert property (@(posedge clk) rst |=> (!mdio_oe && !reg_we && !reg_re));
endmodule

// File: tb/test_mgmt_frame_slave.sv
module test_mgmt_frame_slave;
  logic clk = 0, rst = 1, din = 1, lis = 0;
  logic mdio_o, mdio_oe, reg_we, reg_re;
  logic [4:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] rf [32];
  int total = 0, fails = 0;
  logic o_s, oe_s, we_s, re_s;
  logic [4:0] a_s;
  logic [15:0] wd_s;

  always #10 clk = ~clk;

  mgmt_frame_slave i_mgmt_frame_slave (
    .clk(clk), .rst(rst), .mdio_i(din), .host_listen(lis),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata));

  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic l);
    @(negedge clk);
    din = b; lis = l;
    #1;
    o_s = mdio_o; oe_s = mdio_oe; we_s = reg_we; re_s = reg_re;
    a_s = reg_addr; wd_s = reg_wdata;
  endtask

  task automatic hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                     output int res, output int wes, output int oes, output logic [4:0] a_last);
    logic [11:0] f;
    f = {op, phy, ra};
    res = 0; wes = 0; oes = 0;
    cyc(0, 0); oes += oe_s;
    cyc(1, 0); oes += oe_s;
    for (int i = 11; i >= 0; i--) begin
      cyc(f[i], 0);
      res += re_s; wes += we_s; oes += oe_s;
    end
    a_last = a_s;
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] ra, input string tag);
    int res, wes, oes, bad_oe;
    logic [4:0] al;
    logic [15:0] v;
    logic [15:0] exp;
    exp = rf[ra];
    hdr(2'b10, phy, ra, res, wes, oes, al);
    chk(res == 1 && re_s && al == ra, {"R4 read strobe/addr ", tag}, {res[7:0], 3'b0, al}, {8'd1, 8'(ra)});
    chk(oes == 0, {"R10 no drive before turnaround ", tag}, oes, 0);
    cyc(0, 1);
    chk(oe_s && !o_s, {"R5 turnaround ", tag}, {oe_s, o_s}, 2'b10);
    bad_oe = 0;
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1);
      v = {v[14:0], o_s};
      if (!oe_s) bad_oe++;
    end
    chk(v == exp, {"R3 R6 read data ", tag}, v, exp);
    chk(bad_oe == 0, {"R6 enable during data ", tag}, bad_oe, 0);
    cyc(1, 0);
    chk(!oe_s && !o_s, {"R6 idle after data ", tag}, oe_s, 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    int res, wes, oes;
    logic [4:0] al;
    hdr(2'b01, phy, ra, res, wes, oes, al);
    cyc(1, 0); wes += we_s; oes += oe_s;
    cyc(0, 0); wes += we_s; oes += oe_s;
    for (int i = 15; i >= 0; i--) begin
      cyc(d[i], 0);
      if (i > 0) wes += we_s;
      oes += oe_s;
    end
    chk(we_s && a_s == ra && wd_s == d, "R7 write strobe addr/data", {we_s, 3'b0, a_s, wd_s}, {1'b1, 3'b0, ra, d});
    chk(wes == 0 && res == 0 && oes == 0, "R7 R10 no early strobe or drive", wes + res + oes, 0);
    cyc(1, 0);
    chk(!we_s && !oe_s, "R7 single strobe", we_s, 0);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) cyc(0, 0);
    chk(!oe_s && !we_s && !re_s && !o_s, "R11 reset outputs", {oe_s, we_s, re_s, o_s}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_idle_ones;
    int d = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0);
      d += oe_s + we_s + re_s;
    end
    chk(d == 0, "R1 idle on ones", d, 0);
    t_read(5'd3, 5'd9, "after ones");
  endtask

  task automatic t_start_wait;
    int res = 0, oes = 0;
    logic [11:0] f;
    logic [15:0] v;
    f = {2'b10, 5'd17, 5'd30};
    for (int i = 0; i < 5; i++) begin cyc(0, 0); oes += oe_s; end
    cyc(1, 0);
    for (int i = 11; i >= 0; i--) begin cyc(f[i], 0); res += re_s; end
    chk(res == 1 && oes == 0, "R2 start waits on zeros", res, 1);
    cyc(0, 1);
    for (int i = 0; i < 16; i++) begin cyc(0, 1); v = {v[14:0], o_s}; end
    chk(v == rf[30], "R2 data after long start", v, rf[30]);
    cyc(1, 0);
  endtask

  task automatic t_bad_op(input logic [1:0] op);
    int res, wes, oes, d;
    logic [4:0] al;
    hdr(op, 5'd1, 5'd4, res, wes, oes, al);
    d = 0;
    for (int i = 0; i < 18; i++) begin
      cyc(1, 0);
      d += we_s + re_s + oe_s;
    end
    chk(res + wes + oes + d == 0, "R8 bad opcode quiet", res + wes + oes + d, 0);
    chk(rf[4] == 16'h1234, "R8 register untouched", rf[4], 16'h1234);
    t_read(5'd0, 5'd4, "after bad op");
  endtask

  task automatic t_abort;
    int res, wes, oes, d;
    logic [4:0] al;
    logic [15:0] keep;
    hdr(2'b10, 5'd2, 5'd7, res, wes, oes, al);
    cyc(0, 1);
    cyc(0, 1); cyc(0, 1);
    cyc(1, 0);
    chk(oe_s, "R9 still driving when host drives", oe_s, 1);
    cyc(1, 0);
    chk(!oe_s && !o_s, "R9 drive abort", oe_s, 0);
    d = 0;
    for (int i = 0; i < 4; i++) begin cyc(0, 1); d += oe_s + o_s + we_s + re_s; end
    chk(d == 0, "R9 listen in idle stays quiet", d, 0);
    keep = rf[12];
    hdr(2'b01, 5'd2, 5'd12, res, wes, oes, al);
    cyc(1, 0); cyc(0, 0);
    for (int i = 0; i < 8; i++) cyc(1, 0);
    cyc(0, 1);
    d = 0;
    for (int i = 0; i < 8; i++) begin cyc(1, 0); d += we_s + oe_s; end
    chk(d == 0 && rf[12] == keep, "R9 write abort", rf[12], keep);
    for (int i = 0; i < 20; i++) cyc(1, 0);
    t_read(5'd2, 5'd12, "after abort");
  endtask

  task automatic t_mid_reset;
    int res, wes, oes;
    logic [4:0] al;
    hdr(2'b10, 5'd5, 5'd8, res, wes, oes, al);
    cyc(0, 1); cyc(0, 1);
    rst = 1;
    cyc(0, 1);
    cyc(0, 1);
    chk(!oe_s && !o_s, "R11 reset mid-read", oe_s, 0);
    @(negedge clk); rst = 0;
    t_read(5'd5, 5'd8, "after mid reset");
  endtask

  initial begin
    for (int k = 0; k < 32; k++) rf[k] = 16'hA5C3 ^ 16'(k * 16'h0357);
    rf[4] = 16'h1234;
    t_reset();
    t_read(5'd0, 5'd1, "phy0 r1");
    t_read(5'd31, 5'd1, "phy31 r1");
    t_read(5'd10, 5'd31, "r31");
    t_idle_ones();
    t_start_wait();
    t_write(5'd6, 5'd16, 16'h8001);
    t_read(5'd22, 5'd16, "readback r16");
    t_write(5'd0, 5'd0, 16'h7FFE);
    t_read(5'd0, 5'd0, "readback r0");
    t_bad_op(2'b00);
    t_bad_op(2'b11);
    t_abort();
    t_mid_reset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule